// File: doc/BRIEF.md
# Device-Paced DMA Word and Address Sequencer

This block sequences a direct memory access transfer whose pace is set by a peripheral rather than by the bus. Software first loads a 16-bit count register with the negated number of words and a 17-bit word address (byte address bits 17:1). It then issues a start command, which pulls READY low. From then on, each rising edge of the device's request line starts one memory cycle. The block captures the device's data word, cycle code, byte-select bit, increment enables and burst choice, and raises a request toward the bus sequencer. When that sequencer reports completion, the count and the address advance in the same clock.

The transfer ends when the count climbs to zero, when the device raises its attention line, or when the bus reports an error. READY then rises again. In burst mode a single request edge runs back-to-back cycles until the transfer ends. BUSY is low from the moment a bus cycle is requested until it completes, and read data is presented to the device by the time BUSY rises.

Top module: `dma_seq`

## Requirements
- R1: After reset READY and BUSY are high, the bus request and the terminal-count pulse are low, and the count and address are zero.
- R2: A start command while READY is high drives READY low on the next clock. Loads of the count or the address are accepted only while READY is high and are ignored otherwise.
- R3: The request input passes through a two-flop synchronizer. Its rising edge, seen while READY is low and no cycle is active, starts a cycle on the third clock edge after the input rises. At that point the bus request goes high and BUSY goes low. The data word, the cycle code {C1,C0}, the byte-select bit, both increment enables and the single-cycle bit are captured at that moment.
- R4: Request edges that arrive while READY is high, or while a cycle is in progress, start no cycle.
- R5: On bus completion, the count increments by one if the captured count enable is 1, and the word address increments by one (byte address +2) if the captured address enable is 1. An enable of 0 leaves its register unchanged.
- R6: The word address is 17 bits wide. A carry out of byte-address bit 15 increments bits 17:16, and an increment from byte address 0x3FFFE wraps to 0.
- R7: Bit 0 of the bus address is the captured byte-select bit from the device.
- R8: When a counted completion brings the count to zero, the cycle ends, READY rises and the terminal-count output pulses high for exactly one clock.
- R9: Cycle code 00 is a word read, 01 a read-pause, 10 a word write and 11 a byte write. For codes with C1=0, the device output data takes the bus read data at completion. Codes with C1=1 leave it unchanged. The bus write data is the captured device data word.
- R10: When the captured single-cycle bit is 0 (burst mode), each completion short of the end of the transfer starts the next cycle immediately, with no further request edge. BUSY stays low until the transfer ends.
- R11: Attention high while READY is low raises READY on the next clock if no cycle is active. If a cycle is active, READY rises at the completion of that cycle, which still updates the count and the address.
- R12: A bus error during a cycle ends it and raises READY, leaving the count and the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_ld_cnt | input | 1 | Load count register |
| sw_cnt | input | 16 | Count value (negated word count) |
| sw_ld_addr | input | 1 | Load word address register |
| sw_addr | input | 17 | Word address, byte-address bits 17:1 |
| sw_start | input | 1 | Start command |
| dev_req | input | 1 | Device cycle request, asynchronous |
| dev_cnt_en | input | 1 | Device count-increment enable |
| dev_addr_en | input | 1 | Device address-increment enable |
| dev_a0 | input | 1 | Device byte-select address bit |
| dev_code | input | 2 | Device cycle code {C1,C0} |
| dev_single | input | 1 | 1 = single cycle, 0 = burst |
| dev_attn | input | 1 | Device attention |
| dev_wdata | input | 16 | Device data toward memory |
| bus_done | input | 1 | Bus cycle completion pulse |
| bus_err | input | 1 | Bus cycle error pulse |
| bus_rdata | input | 16 | Memory read data |
| ready | output | 1 | READY handshake to device |
| busy | output | 1 | BUSY handshake, low during a cycle |
| bus_req | output | 1 | Cycle request to bus sequencer |
| bus_addr | output | 18 | Byte address of current cycle |
| bus_code | output | 2 | Captured cycle code |
| bus_wdata | output | 16 | Captured write data |
| dev_rdata | output | 16 | Read data to device |
| word_cnt | output | 16 | Current count register |
| tc_pulse | output | 1 | Terminal-count event, one clock |

## Verification
The embedded properties watch, on every clock, the rules that stay local in time. The count moves only on a completion or an accepted load. The address steps by exactly one word on an enabled completion. READY held high never lets a bus request appear. BUSY rises only after a completion or an error, and the terminal-count pulse coincides with READY and a zero count. The directed scenarios are needed for the behaviour that spans many cycles or depends on captured state. These include synchronizer latency, edges discarded while idle or mid-cycle, carry into the extension bits and the final wrap, burst runs without further requests, attention during a cycle, and read data that survives write cycles.

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int CW = 16,
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_ld_cnt,
  input  logic [CW-1:0] sw_cnt,
  input  logic          sw_ld_addr,
  input  logic [AW-1:0] sw_addr,
  input  logic          sw_start,
  input  logic          dev_req,
  input  logic          dev_cnt_en,
  input  logic          dev_addr_en,
  input  logic          dev_a0,
  input  logic [1:0]    dev_code,
  input  logic          dev_single,
  input  logic          dev_attn,
  input  logic [DW-1:0] dev_wdata,
  input  logic          bus_done,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          ready,
  output logic          busy,
  output logic          bus_req,
  output logic [AW:0]   bus_addr,
  output logic [1:0]    bus_code,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic [CW-1:0] word_cnt,
  output logic          tc_pulse
);

  logic [2:0]    req_s;
  logic          rdy_q, act_q, tc_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_l, dout_q;
  logic [1:0]    code_l;
  logic          a0_l, cen_l, aen_l, single_l;

  wire           req_edge = req_s[1] & ~req_s[2];
  wire [CW-1:0]  cnt_inc  = cnt_q + 1'b1;
  wire           last     = cen_l && (cnt_inc == '0);
  wire           fin      = act_q && bus_done && !bus_err;
  wire           launch   = !rdy_q && !act_q && !dev_attn && req_edge;
  wire           chain    = fin && !last && !dev_attn && !single_l;
  wire           cap      = launch || chain;

  assign ready     = rdy_q;
  assign busy      = ~act_q;
  assign bus_req   = act_q;
  assign bus_addr  = {addr_q, a0_l};
  assign bus_code  = code_l;
  assign bus_wdata = din_l;
  assign dev_rdata = dout_q;
  assign word_cnt  = cnt_q;
  assign tc_pulse  = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_s  <= '0;
      rdy_q  <= 1'b1;
      act_q  <= 1'b0;
      tc_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      req_s <= {req_s[1:0], dev_req};
      tc_q  <= 1'b0;
      if (rdy_q) begin
        if (sw_ld_cnt)  cnt_q  <= sw_cnt;
        if (sw_ld_addr) addr_q <= sw_addr;
        if (sw_start)   rdy_q  <= 1'b0;
      end else if (!act_q) begin
        if (dev_attn)      rdy_q <= 1'b1;
        else if (req_edge) act_q <= 1'b1;
      end else if (bus_err) begin
        act_q <= 1'b0;
        rdy_q <= 1'b1;
      end else if (bus_done) begin
        if (cen_l)      cnt_q  <= cnt_inc;
        if (aen_l)      addr_q <= addr_q + 1'b1;
        if (!code_l[1]) dout_q <= bus_rdata;
        if (last || dev_attn) begin
          act_q <= 1'b0;
          rdy_q <= 1'b1;
          tc_q  <= last;
        end else if (single_l) begin
          act_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_l <= '0; code_l <= '0; a0_l <= 1'b0;
      cen_l <= 1'b0; aen_l <= 1'b0; single_l <= 1'b1;
    end else if (cap) begin
      din_l    <= dev_wdata;
      code_l   <= dev_code;
      a0_l     <= dev_a0;
      cen_l    <= dev_cnt_en;
      aen_l    <= dev_addr_en;
      single_l <= dev_single;
    end
  end

  // R4
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !act_q) |=> !bus_req);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(act_q && bus_done) && !(rdy_q && sw_ld_cnt)) |=> $stable(word_cnt));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && aen_l) |=> (bus_addr[AW:1] == $past(bus_addr[AW:1]) + 1'b1));

  // R8
  tc_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (ready && busy && word_cnt == '0));

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_done || bus_err));

  // R2
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sw_start) |=> !ready);

endmodule

// File: tb/dma_seq_test.sv
module dma_seq_test;
  logic clk = 0, rst_n = 0;
  logic sw_ld_cnt = 0, sw_ld_addr = 0, sw_start = 0;
  logic [15:0] sw_cnt = 0;
  logic [16:0] sw_addr = 0;
  logic dev_req = 0, dev_cnt_en = 1, dev_addr_en = 1, dev_a0 = 0, dev_single = 1, dev_attn = 0;
  logic [1:0] dev_code = 2'b10;
  logic [15:0] dev_wdata = 0, bus_rdata = 0;
  logic bus_done = 0, bus_err = 0;
  logic ready, busy, bus_req, tc_pulse;
  logic [17:0] bus_addr;
  logic [1:0] bus_code;
  logic [15:0] bus_wdata, dev_rdata, word_cnt;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_seq uut (.clk, .rst_n, .sw_ld_cnt, .sw_cnt, .sw_ld_addr, .sw_addr, .sw_start,
    .dev_req, .dev_cnt_en, .dev_addr_en, .dev_a0, .dev_code, .dev_single, .dev_attn,
    .dev_wdata, .bus_done, .bus_err, .bus_rdata, .ready, .busy, .bus_req, .bus_addr,
    .bus_code, .bus_wdata, .dev_rdata, .word_cnt, .tc_pulse);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] c, input logic [16:0] a);
    @(negedge clk); sw_ld_cnt = 1; sw_cnt = c; sw_ld_addr = 1; sw_addr = a;
    @(negedge clk); sw_ld_cnt = 0; sw_ld_addr = 0; sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic req_pulse();
    @(negedge clk); dev_req = 1;
    repeat (3) @(negedge clk);
    dev_req = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic done_pulse(input logic err);
    bus_done = !err; bus_err = err;
    @(negedge clk); bus_done = 0; bus_err = 0;
  endtask

  task automatic t_reset();
    chk(ready && busy && !bus_req && !tc_pulse, "R1 idle outputs", {ready, busy, bus_req, tc_pulse}, 4'b1100);
    chk(word_cnt == 0 && bus_addr == 0, "R1 registers", word_cnt, 0);
  endtask

  task automatic t_ignore_idle();
    req_pulse();
    repeat (3) @(negedge clk);
    chk(!bus_req && busy, "R4 edge while ready", bus_req, 0);
  endtask

  task automatic t_main();
    setup(16'hFFFD, 17'h00100);
    chk(!ready, "R2 start drops ready", ready, 0);
    @(negedge clk); sw_ld_cnt = 1; sw_cnt = 16'h1234;
    @(negedge clk); sw_ld_cnt = 0;
    chk(word_cnt == 16'hFFFD, "R2 load ignored while busy", word_cnt, 16'hFFFD);
    dev_code = 2'b10; dev_wdata = 16'hA5A5; dev_a0 = 0; dev_single = 1;
    @(negedge clk); dev_req = 1;
    @(negedge clk); @(negedge clk);
    chk(!bus_req, "R3 not before third edge", bus_req, 0);
    @(negedge clk);
    chk(bus_req && !busy, "R3 cycle starts", bus_req, 1);
    chk(bus_code == 2'b10 && bus_wdata == 16'hA5A5 && bus_addr == 18'h200, "R3 capture", bus_addr, 18'h200);
    dev_req = 0; dev_wdata = 16'h0000;
    repeat (3) @(negedge clk);
    dev_req = 1; repeat (4) @(negedge clk); dev_req = 0;
    chk(bus_wdata == 16'hA5A5, "R4 mid-cycle edge recaptures nothing", bus_wdata, 16'hA5A5);
    done_pulse(0);
    chk(busy && !bus_req && word_cnt == 16'hFFFE && bus_addr == 18'h202, "R5 both advance", bus_addr, 18'h202);
    repeat (4) @(negedge clk);
    chk(!bus_req, "R4 edge during cycle dropped", bus_req, 0);
    dev_code = 2'b11; dev_a0 = 1; dev_cnt_en = 0;
    req_pulse();
    chk(bus_addr == 18'h203 && bus_code == 2'b11, "R7 byte bit", bus_addr, 18'h203);
    done_pulse(0);
    chk(word_cnt == 16'hFFFE && bus_addr[17:1] == 17'h102, "R5 count inhibited", word_cnt, 16'hFFFE);
    dev_cnt_en = 1; dev_addr_en = 0; dev_a0 = 0; dev_code = 2'b00; bus_rdata = 16'h1357;
    req_pulse();
    done_pulse(0);
    chk(word_cnt == 16'hFFFF && bus_addr == 18'h204, "R5 address inhibited", bus_addr, 18'h204);
    chk(dev_rdata == 16'h1357, "R9 read data", dev_rdata, 16'h1357);
    dev_addr_en = 1; bus_rdata = 16'h2468;
    req_pulse();
    done_pulse(0);
    chk(ready && busy && tc_pulse && word_cnt == 0, "R8 terminal count", {ready, tc_pulse}, 2'b11);
    chk(dev_rdata == 16'h2468, "R9 read data second", dev_rdata, 16'h2468);
    @(negedge clk);
    chk(!tc_pulse, "R8 pulse one clock", tc_pulse, 0);
  endtask

  task automatic t_carry();
    setup(16'hFFFE, 17'h0FFFF);
    dev_code = 2'b10; bus_rdata = 16'hDEAD;
    req_pulse();
    chk(bus_addr == 18'h1FFFE, "R6 start address", bus_addr, 18'h1FFFE);
    done_pulse(0);
    chk(bus_addr == 18'h20000, "R6 carry into extension", bus_addr, 18'h20000);
    chk(dev_rdata == 16'h2468, "R9 write keeps read data", dev_rdata, 16'h2468);
    req_pulse(); done_pulse(0);
    setup(16'hFFFF, 17'h1FFFF);
    req_pulse();
    chk(bus_addr == 18'h3FFFE, "R6 top address", bus_addr, 18'h3FFFE);
    done_pulse(0);
    chk(bus_addr == 0 && ready, "R6 wrap to zero", bus_addr, 0);
  endtask

  task automatic t_burst();
    setup(16'hFFFD, 17'h00010);
    dev_single = 0; dev_code = 2'b10;
    req_pulse();
    for (int i = 0; i < 2; i++) begin
      done_pulse(0);
      chk(bus_req && !busy && !ready, "R10 burst continues", bus_req, 1);
    end
    done_pulse(0);
    chk(ready && busy && !bus_req && bus_addr == 18'h26, "R10 burst end", bus_addr, 18'h26);
    dev_single = 1;
  endtask

  task automatic t_attn();
    setup(16'hFFF0, 17'h00020);
    dev_attn = 1; @(negedge clk); dev_attn = 0;
    chk(ready, "R11 attention while idle", ready, 1);
    @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
    req_pulse();
    dev_attn = 1; @(negedge clk);
    chk(bus_req && !ready, "R11 cycle kept", bus_req, 1);
    done_pulse(0); dev_attn = 0;
    chk(ready && word_cnt == 16'hFFF1 && !tc_pulse, "R11 ends after cycle", word_cnt, 16'hFFF1);
  endtask

  task automatic t_err();
    setup(16'hFFF0, 17'h00040);
    req_pulse();
    done_pulse(1);
    chk(ready && busy && word_cnt == 16'hFFF0 && bus_addr == 18'h80, "R12 error abort", word_cnt, 16'hFFF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore_idle();
    t_main();
    t_carry();
    t_burst();
    t_attn();
    t_err();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule